// File: doc/BRIEF.md
# Excess-one carry-select adder

This block adds two unsigned operands and a carry-in with no clock. The operands are cut into fixed 4-bit slices. Each slice above the lowest one works out its result twice, both at once. The first result comes from a 4-bit ripple chain that assumes no carry enters the slice. The second result assumes a carry of one, and a small +1 converter builds it from the first result, so no second ripple chain is needed.

When the real carry reaches a slice, it only has to steer a set of 2:1 multiplexers. It does not ripple through the slice's full adders again. The lowest slice is a plain ripple chain fed by the external carry-in. The carry chosen by each slice becomes the select for the slice above it.

The block can stand in for any combinational adder whose width is a multiple of four.

Top module: `csel_exc1_adder`

## Requirements
- R1: A slice's ripple chain, with carry-in 0, produces the 4-bit sum and the carry of the two 4-bit slice operands.
- R2: The +1 converter takes the 5-bit value {carry, sum} of the carry-in-0 chain and returns that value plus one, modulo 32. Its bit 0 is the inverse of input bit 0, and each higher bit is the input bit XORed with the AND of all lower input bits.
- R3: The lowest slice (bits 3:0) adds the external `cin` directly in its ripple chain.
- R4: A higher slice outputs its carry-in-0 sum and carry when the carry entering it is 0. It outputs the converter's sum and carry when that carry is 1.
- R5: The carry entering slice k (k > 0) is the carry that slice k-1 has selected.
- R6: `sum` equals (a + b + cin) modulo 2^WIDTH, for all operand values.
- R7: `cout` equals bit WIDTH of the full result a + b + cin.
- R8: All-ones plus one (an operand of all ones and cin = 1, or an equivalent pattern) yields `sum` = 0 and `cout` = 1, with the carry crossing every slice.
- R9: Zero operands give `sum` = 0, `cout` = 0 when cin = 0, and `sum` = 1, `cout` = 0 when cin = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First addend |
| b | input | WIDTH | Second addend |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Result modulo 2^WIDTH |
| cout | output | 1 | Carry out of the top bit |

## Verification
Each input pattern is chosen to isolate one part of the design:
- **Carries confined to one slice** (for example 0x1234 + 0x4321) exercise only the carry-in-0 ripple chains and the zero-select path.
- **A carry produced in one slice and consumed by the next** (0x000F + 0 + 1, 0x00F0 + 0x0010) proves that each select comes from the slice below.
- **A slice that carries on its own and also receives a carry** (0x0081 + 0x008F) drives the +1 converter with its carry bit set.
- **Full-length carry chains** (all ones plus one, 0xAAAA + 0x5555 + 1) cross every multiplexer.
- **Random vectors** checked against a behavioural sum catch any mis-wired bit.

// File: rtl/csel_pkg.sv
package csel_pkg;

    localparam int GRP_W = 4;

    typedef struct packed {
        logic             cy;
        logic [GRP_W-1:0] s;
    } grp_res_t;

    // one-bit full adder: {carry, sum}
    function automatic logic [1:0] fa_bit(input logic x, input logic y, input logic z);
        return {(x & y) | (z & (x ^ y)), x ^ y ^ z};
    endfunction

    function automatic grp_res_t pick_res(input logic sel, input grp_res_t r0, input grp_res_t r1);
        return sel ? r1 : r0;
    endfunction

endpackage

// File: rtl/csel_rca.sv
module csel_rca
    import csel_pkg::*;
(
    input  logic [GRP_W-1:0] a,
    input  logic [GRP_W-1:0] b,
    input  logic             ci,
    output grp_res_t         res
);
    logic [GRP_W:0] c;
    logic [GRP_W-1:0] s;

    assign c[0] = ci;

    for (genvar i = 0; i < GRP_W; i++) begin : g_fa
        assign {c[i+1], s[i]} = fa_bit(a[i], b[i], c[i]);
    end

    assign res.cy = c[GRP_W];
    assign res.s  = s;

    always_comb begin
        assert_rca_sum_R1: assert ({res.cy, res.s} ==
            ({1'b0, a} + {1'b0, b} + (GRP_W+1)'(ci)))
            else $error("ripple slice result wrong");
    end
endmodule

// File: rtl/csel_exc1.sv
module csel_exc1 #(
    parameter int W = 5
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    // run[i] = AND of din[i:0]
    logic [W-2:0] run;

    assign run[0]  = din[0];
    assign dout[0] = ~din[0];

    for (genvar i = 1; i < W - 1; i++) begin : g_run
        assign run[i] = run[i-1] & din[i];
    end

    for (genvar i = 1; i < W; i++) begin : g_out
        assign dout[i] = din[i] ^ run[i-1];
    end

    always_comb begin
        assert_exc1_inc_R2: assert (dout == din + W'(1))
            else $error("excess-one converter wrong");
    end
endmodule

// File: rtl/csel_grp.sv
module csel_grp
    import csel_pkg::*;
(
    input  logic [GRP_W-1:0] a,
    input  logic [GRP_W-1:0] b,
    input  logic             sel,
    output grp_res_t         res
);
    grp_res_t r0;
    grp_res_t r1;

    csel_rca u_rca (
        .a  (a),
        .b  (b),
        .ci (1'b0),
        .res(r0)
    );

    csel_exc1 #(.W(GRP_W + 1)) u_exc1 (
        .din ({r0.cy, r0.s}),
        .dout({r1.cy, r1.s})
    );

    assign res = pick_res(sel, r0, r1);

    always_comb begin
        assert_grp_sel_R4: assert ({res.cy, res.s} ==
            ({1'b0, a} + {1'b0, b} + (GRP_W+1)'(sel)))
            else $error("slice selection wrong");
        // a carry-in-0 carry must survive in the carry-in-1 candidate
        assert_grp_cy_R2: assert (!r0.cy || r1.cy)
            else $error("candidate carries inconsistent");
    end
endmodule

// File: rtl/csel_exc1_adder.sv
module csel_exc1_adder
    import csel_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    localparam int NUM_GRP = WIDTH / GRP_W;

    logic [NUM_GRP:0] carry;
    grp_res_t         res [NUM_GRP];

    assign carry[0] = cin;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_slice
        if (g == 0) begin : g_low
            csel_rca u_low (
                .a  (a[GRP_W-1:0]),
                .b  (b[GRP_W-1:0]),
                .ci (carry[0]),
                .res(res[0])
            );
        end else begin : g_high
            csel_grp u_grp (
                .a  (a[g*GRP_W +: GRP_W]),
                .b  (b[g*GRP_W +: GRP_W]),
                .sel(carry[g]),
                .res(res[g])
            );
        end
        assign carry[g+1]             = res[g].cy;
        assign sum[g*GRP_W +: GRP_W]  = res[g].s;
    end

    assign cout = carry[NUM_GRP];

    always_comb begin
        assert_full_sum_R6: assert (sum == (a + b + WIDTH'(cin)))
            else $error("sum wrong");
        assert_full_cout_R7: assert ({cout, sum} ==
            ({1'b0, a} + {1'b0, b} + (WIDTH+1)'(cin)))
            else $error("carry out wrong");
    end
endmodule

// File: tb/csel_exc1_adder_bench.sv
module csel_exc1_adder_bench;
    localparam int WIDTH = 16;
    localparam int NVEC  = 16;
    localparam int NRND  = 300;

    // {a, b, cin, expected {cout, sum}}
    localparam logic [49:0] VEC [NVEC] = '{
        {16'h0000, 16'h0000, 1'b0, 17'h00000},
        {16'h0000, 16'h0000, 1'b1, 17'h00001},
        {16'hFFFF, 16'h0000, 1'b1, 17'h10000},
        {16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF},
        {16'hFFFF, 16'hFFFF, 1'b0, 17'h1FFFE},
        {16'hAAAA, 16'h5555, 1'b0, 17'h0FFFF},
        {16'hAAAA, 16'h5555, 1'b1, 17'h10000},
        {16'h000F, 16'h0000, 1'b1, 17'h00010},
        {16'h00F0, 16'h0010, 1'b0, 17'h00100},
        {16'h0F00, 16'h0100, 1'b0, 17'h01000},
        {16'hF000, 16'h1000, 1'b0, 17'h10000},
        {16'h1234, 16'h4321, 1'b0, 17'h05555},
        {16'h8000, 16'h8000, 1'b1, 17'h10001},
        {16'h7FFF, 16'h0001, 1'b0, 17'h08000},
        {16'h0081, 16'h008F, 1'b0, 17'h00110},
        {16'h5555, 16'h5555, 1'b1, 17'h0AAAB}
    };

    logic             clk = 1'b0;
    logic [WIDTH-1:0] a   = '0;
    logic [WIDTH-1:0] b   = '0;
    logic             cin = 1'b0;
    logic [WIDTH-1:0] sum;
    logic             cout;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #4 clk = ~clk;

    csel_exc1_adder #(.WIDTH(WIDTH)) u_csel_exc1_adder (
        .a   (a),
        .b   (b),
        .cin (cin),
        .sum (sum),
        .cout(cout)
    );

    task automatic check(input string req, input logic [16:0] got, input logic [16:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s a=%h b=%h cin=%b got=%h exp=%h", req, a, b, cin, got, exp);
        end
    endtask

    task automatic apply(input logic [15:0] va, input logic [15:0] vb, input logic vc);
        @(posedge clk);
        a   = va;
        b   = vb;
        cin = vc;
        @(negedge clk);
    endtask

    task automatic run_pair(input string rs, input string rc,
                            input logic [15:0] va, input logic [15:0] vb, input logic vc,
                            input logic [16:0] exp);
        apply(va, vb, vc);
        check(rs, {1'b0, sum}, {1'b0, exp[15:0]});
        check(rc, {16'b0, cout}, {16'b0, exp[16]});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        // idle state: zero inputs settle to zero (R9)
        @(negedge clk);
        check("R9 idle", {cout, sum}, 17'h00000);

        for (int i = 0; i < NVEC; i++) begin
            run_pair("R6 table sum", "R7 table cout",
                     VEC[i][49:34], VEC[i][33:18], VEC[i][17], VEC[i][16:0]);
        end

        // directed cases
        run_pair("R9 zero cin1 sum", "R9 zero cin1 cout", 16'h0000, 16'h0000, 1'b1, 17'h00001);
        run_pair("R8 ones+1 sum", "R8 ones+1 cout", 16'hFFFF, 16'h0000, 1'b1, 17'h10000);
        run_pair("R3 low cin sum", "R3 low cin cout", 16'h0007, 16'h0008, 1'b1, 17'h00010);
        run_pair("R5 chained select sum", "R5 chained select cout", 16'h000F, 16'h0000, 1'b1, 17'h00010);
        run_pair("R4 select one sum", "R4 select one cout", 16'h00F0, 16'h0010, 1'b0, 17'h00100);
        run_pair("R4 select zero sum", "R4 select zero cout", 16'h00F0, 16'h0000, 1'b1, 17'h000F1);
        run_pair("R2 converter carry sum", "R2 converter carry cout", 16'h0081, 16'h008F, 1'b0, 17'h00110);
        run_pair("R1 in-slice only sum", "R1 in-slice only cout", 16'h1234, 16'h4321, 1'b0, 17'h05555);

        // random vectors against a behavioural sum
        for (int i = 0; i < NRND; i++) begin
            logic [15:0] ra;
            logic [15:0] rb;
            logic        rc;
            logic [16:0] ref_sum;
            ra      = 16'($urandom);
            rb      = 16'($urandom);
            rc      = 1'($urandom);
            ref_sum = {1'b0, ra} + {1'b0, rb} + {16'b0, rc};
            run_pair("R6 random sum", "R7 random cout", ra, rb, rc, ref_sum);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule